// File: doc/BRIEF.md
# Port-Mapped IO Decoder

This block sits on the peripheral side of the port bus of a small 8-bit soft processor. The processor presents an 8-bit port address, an 8-bit write byte and two strobes. On the output side, each bit of the address picks one 8-bit output register (one-hot selection). Setting several address bits in one write loads several registers with the same byte. On the input side, the low three address bits pick one of up to eight 8-bit sources through a registered binary multiplexer. Its result is ready in the second cycle of a two-cycle input instruction, which is when the processor samples it.

One input source, the status port, carries a sticky data-ready flag in its bit 0. A peripheral raises the flag with a one-cycle set pulse. The read strobe that addresses the status port clears it. For systems with a single port, a bypass parameter removes all decoding: every write goes to register 0 and every read returns source 0.

Top module: `portio_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, every output register, the sticky flag and `inPort` become zero by the following cycle.
- R2: At a clock edge where `writeStrobe` is 1 and bit i of `portId` is 1 (i < NUM_OUT), output register i loads `outData`. Register i occupies `portOut[8i+7:8i]`. The new value is visible in the cycle after that edge. Several set bits load several registers in the same edge.
- R3: An output register keeps its value when `writeStrobe` is 0, and also when its address bit is 0. A write to address 0x00 changes no register.
- R4: At each clock edge `inPort` captures source `portId[2:0]`, where source i is `inData[8i+7:8i]`. The value is visible one cycle after the address is applied.
- R5: Address bits 7 to 3 have no effect on input selection. Addresses 0x2B and 0x03 return the same source.
- R6: On the status port (index STATUS_IDX, default 7), bit 0 of the returned byte is the sticky flag and not the source's bit 0. A read strobe with `portId[2:0]` equal to STATUS_IDX clears the flag. A read strobe to any other index leaves it set.
- R7: A `readySet` pulse sets the flag at that clock edge. When a set and a clearing read strobe occur in the same cycle, the set wins and the flag ends up 1.
- R8: With BYPASS=1, register 0 loads on any write strobe whatever the address, and registers 1 and above stay zero. `inPort` returns source 0 for any address, with the flag in bit 0. Any read strobe clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| portId | input | 8 | Port address from the processor |
| writeStrobe | input | 1 | Write qualifier, one cycle |
| readStrobe | input | 1 | Read acknowledge, one cycle |
| outData | input | 8 | Write byte from the processor |
| inData | input | NUM_IN*8 | Input sources, source i in bits 8i+7:8i |
| readySet | input | 1 | Sets the sticky data-ready flag |
| portOut | output | NUM_OUT*8 | Output registers, register i in bits 8i+7:8i |
| inPort | output | 8 | Registered input byte to the processor |

## Verification
Some behaviours are checked by assertions on every cycle:
- a strobed write loading each addressed register, and unaddressed or unstrobed registers holding (R2, R3);
- the reset clearing every output, the flag and `inPort` (R1);
- the set pulse always leaving the flag high (R7);
- a status read without a simultaneous set always clearing the flag (R6, and R8 for the bypass build);
- source 0 reaching `inPort` one cycle after its address (R4).

Other behaviours can only be shown by the bench's scenarios:
- aliasing of the upper address bits on input (R5);
- the flag surviving a read of a different index (R6);
- the ordering of set against clear as seen through the status byte (R7);
- the values a bypass build returns (R8).

// File: rtl/portio_pkg.sv
package portio_pkg;
  localparam int MAX_PORTS = 8;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic [MAX_PORTS-1:0] outLoad;
    logic [SEL_W-1:0]     inSel;
    logic                 inValid;
    logic                 flagClr;
  } portio_ctrl_t;
endpackage

// File: rtl/portio_ctrl.sv
module portio_ctrl
  import portio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_IN = 8,
  parameter int STATUS_IDX = 7,
  parameter bit BYPASS = 1'b0
) (
  input  logic [ADDR_W-1:0] portId,
  input  logic              writeStrobe,
  input  logic              readStrobe,
  output portio_ctrl_t      strobes
);
  localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(STATUS_IDX);

  logic unusedAddr;
  assign unusedAddr = ^portId;

  always_comb begin
    strobes = '0;
    if (BYPASS) begin
      strobes.outLoad[0] = writeStrobe;
      strobes.inSel      = '0;
      strobes.inValid    = 1'b1;
      strobes.flagClr    = readStrobe;
    end else begin
      for (int i = 0; i < MAX_PORTS; i++) begin
        if (i < NUM_OUT && i < ADDR_W) begin
          strobes.outLoad[i] = writeStrobe & portId[i];
        end
      end
      strobes.inSel   = portId[SEL_W-1:0];
      strobes.inValid = (int'(portId[SEL_W-1:0]) < NUM_IN);
      strobes.flagClr = readStrobe && (portId[SEL_W-1:0] == STAT_SEL);
    end
  end
endmodule

// File: rtl/portio_dpath.sv
module portio_dpath
  import portio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_IN = 8,
  parameter int STATUS_IDX = 7,
  parameter bit BYPASS = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  portio_ctrl_t              strobes,
  input  logic [DATA_W-1:0]         outData,
  input  logic [NUM_IN*DATA_W-1:0]  inData,
  input  logic                      readySet,
  output logic [NUM_OUT*DATA_W-1:0] portOut,
  output logic [DATA_W-1:0]         inPort
);
  localparam int STAT_SEL = BYPASS ? 0 : STATUS_IDX;

  logic readyFlag;
  logic [DATA_W-1:0] srcArr [MAX_PORTS];
  logic [DATA_W-1:0] selByte;

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
    if (!BYPASS || g == 0) begin : gReg
      logic [DATA_W-1:0] regQ;
      always_ff @(posedge clk) begin
        if (rst) regQ <= '0;
        else if (strobes.outLoad[g]) regQ <= outData;
      end
      assign portOut[g*DATA_W +: DATA_W] = regQ;
    end else begin : gTie
      assign portOut[g*DATA_W +: DATA_W] = '0;
    end
  end

  for (genvar g = 0; g < MAX_PORTS; g++) begin : gSrc
    if (g < NUM_IN && g == STAT_SEL) begin : gStat
      assign srcArr[g] = {inData[g*DATA_W+1 +: DATA_W-1], readyFlag};
    end else if (g < NUM_IN) begin : gData
      assign srcArr[g] = inData[g*DATA_W +: DATA_W];
    end else begin : gNone
      assign srcArr[g] = '0;
    end
  end

  always_comb begin
    selByte = strobes.inValid ? srcArr[strobes.inSel] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) inPort <= '0;
    else inPort <= selByte;
  end

  always_ff @(posedge clk) begin
    if (rst) readyFlag <= 1'b0;
    else if (readySet) readyFlag <= 1'b1;
    else if (strobes.flagClr) readyFlag <= 1'b0;
  end
endmodule

// File: rtl/portio_decoder.sv
module portio_decoder
  import portio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_IN = 8,
  parameter int STATUS_IDX = 7,
  parameter bit BYPASS = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         portId,
  input  logic                      writeStrobe,
  input  logic                      readStrobe,
  input  logic [DATA_W-1:0]         outData,
  input  logic [NUM_IN*DATA_W-1:0]  inData,
  input  logic                      readySet,
  output logic [NUM_OUT*DATA_W-1:0] portOut,
  output logic [DATA_W-1:0]         inPort
);
  portio_ctrl_t strobes;

  portio_ctrl #(
    .ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN),
    .STATUS_IDX(STATUS_IDX), .BYPASS(BYPASS)
  ) uCtrl (
    .portId(portId), .writeStrobe(writeStrobe),
    .readStrobe(readStrobe), .strobes(strobes)
  );

  portio_dpath #(
    .DATA_W(DATA_W), .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN),
    .STATUS_IDX(STATUS_IDX), .BYPASS(BYPASS)
  ) uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .outData(outData),
    .inData(inData), .readySet(readySet), .portOut(portOut), .inPort(inPort)
  );
endmodule

// File: rtl/portio_decoder_chk.sv
module portio_decoder_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NUM_OUT = 8,
  parameter int NUM_IN = 8,
  parameter int STATUS_IDX = 7,
  parameter bit BYPASS = 1'b0
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         portId,
  input logic                      writeStrobe,
  input logic                      readStrobe,
  input logic [DATA_W-1:0]         outData,
  input logic [NUM_IN*DATA_W-1:0]  inData,
  input logic                      readySet,
  input logic [NUM_OUT*DATA_W-1:0] portOut,
  input logic [DATA_W-1:0]         inPort,
  input logic                      readyFlag
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (portOut == '0 && !readyFlag && inPort == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !writeStrobe |=> $stable(portOut)); // R3

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    readySet |=> readyFlag); // R7

  if (!BYPASS) begin : gDec
    for (genvar g = 0; g < NUM_OUT; g++) begin : gPort
      AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (writeStrobe && portId[g]) |=> portOut[g*DATA_W +: DATA_W] == $past(outData)); // R2
      AST_WR_SKIP: assert property (@(posedge clk) disable iff (rst)
        (writeStrobe && !portId[g]) |=> $stable(portOut[g*DATA_W +: DATA_W])); // R3
    end
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (readStrobe && portId[2:0] == 3'(STATUS_IDX) && !readySet) |=> !readyFlag); // R6
    if (STATUS_IDX != 0) begin : gSrc0
      AST_IN_SRC0: assert property (@(posedge clk) disable iff (rst)
        (portId[2:0] == 3'd0) |=> inPort == $past(inData[DATA_W-1:0])); // R4
    end
  end else begin : gByp
    AST_BYP_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (readStrobe && !readySet) |=> !readyFlag); // R8
  end
endmodule

bind portio_decoder portio_decoder_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN),
  .STATUS_IDX(STATUS_IDX), .BYPASS(BYPASS)
) uChk (
  .clk(clk), .rst(rst), .portId(portId), .writeStrobe(writeStrobe),
  .readStrobe(readStrobe), .outData(outData), .inData(inData),
  .readySet(readySet), .portOut(portOut), .inPort(inPort),
  .readyFlag(uDp.readyFlag)
);

// File: tb/sim_portio_decoder.sv
`timescale 1ns/1ps
module sim_portio_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] portId = '0;
  logic writeStrobe = 1'b0;
  logic readStrobe = 1'b0;
  logic [7:0] outData = '0;
  logic [63:0] inData;
  logic readySet = 1'b0;
  logic [63:0] portOut, portOutB;
  logic [7:0] inPort, inPortB;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : gIn
    assign inData[g*8 +: 8] = 8'hC0 | 8'(g);
  end

  portio_decoder u0 (
    .clk(clk), .rst(rst), .portId(portId), .writeStrobe(writeStrobe),
    .readStrobe(readStrobe), .outData(outData), .inData(inData),
    .readySet(readySet), .portOut(portOut), .inPort(inPort)
  );

  portio_decoder #(.BYPASS(1'b1)) u1 (
    .clk(clk), .rst(rst), .portId(portId), .writeStrobe(writeStrobe),
    .readStrobe(readStrobe), .outData(outData), .inData(inData),
    .readySet(readySet), .portOut(portOutB), .inPort(inPortB)
  );

  localparam int NV = 6;
  localparam logic [7:0]  V_ID  [NV] = '{8'h01, 8'h80, 8'h06, 8'h00, 8'h10, 8'hFF};
  localparam logic [7:0]  V_DAT [NV] = '{8'h11, 8'hA5, 8'h3C, 8'hFF, 8'h77, 8'h5A};
  localparam logic        V_WR  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0000000000000011, 64'hA500000000000011, 64'hA5000000003C3C11,
    64'hA5000000003C3C11, 64'hA5000000003C3C11, 64'h5A5A5A5A5A5A5A5A};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] id, input logic [7:0] d, input logic wr);
    @(negedge clk); portId = id; outData = d; writeStrobe = 1'b0;
    @(negedge clk); writeStrobe = wr;
    @(negedge clk); writeStrobe = 1'b0;
  endtask

  task automatic setAddr(input logic [7:0] id);
    @(negedge clk); portId = id;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", portOut, 64'h0);
    check("R1 reset inPort", {56'h0, inPort}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      busWrite(V_ID[i], V_DAT[i], V_WR[i]);
      check((i == 3 || i == 4) ? "R3 hold" : "R2 load", portOut, V_EXP[i]);
    end

    busWrite(8'h40, 8'h9E, 1'b1);
    check("R2 single bit 6", portOut, 64'h5A9E5A5A5A5A5A5A);
    check("R8 bypass reg0 any address", {56'h0, portOutB[7:0]}, 64'h9E);
    check("R8 bypass upper regs zero", {8'h0, portOutB[63:8]}, 64'h0);

    setAddr(8'h03);
    check("R4 input source 3", {56'h0, inPort}, 64'hC3);
    setAddr(8'h00);
    check("R4 input source 0", {56'h0, inPort}, 64'hC0);
    setAddr(8'h2B);
    check("R5 upper bits ignored", {56'h0, inPort}, 64'hC3);
    setAddr(8'h07);
    check("R6 status flag clear", {56'h0, inPort}, 64'hC6);

    @(negedge clk); readySet = 1'b1;
    @(negedge clk); readySet = 1'b0;
    @(negedge clk);
    check("R7 flag set", {56'h0, inPort}, 64'hC7);

    @(negedge clk); portId = 8'h03; readStrobe = 1'b1;
    @(negedge clk); readStrobe = 1'b0; portId = 8'h07;
    @(negedge clk);
    check("R6 other index keeps flag", {56'h0, inPort}, 64'hC7);

    @(negedge clk); readStrobe = 1'b1;
    @(negedge clk); readStrobe = 1'b0;
    @(negedge clk);
    check("R6 status read clears flag", {56'h0, inPort}, 64'hC6);

    @(negedge clk); readySet = 1'b1; readStrobe = 1'b1;
    @(negedge clk); readySet = 1'b0; readStrobe = 1'b0;
    @(negedge clk);
    check("R7 set beats clear", {56'h0, inPort}, 64'hC7);

    setAddr(8'h55);
    check("R8 bypass source 0 with flag", {56'h0, inPortB}, 64'hC1);
    @(negedge clk); readStrobe = 1'b1;
    @(negedge clk); readStrobe = 1'b0;
    @(negedge clk);
    check("R8 bypass any read clears", {56'h0, inPortB}, 64'hC0);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset mid-run outputs", portOut, 64'h0);
    setAddr(8'h07);
    check("R1 reset clears flag", {56'h0, inPort}, 64'hC6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule